// File: doc/BRIEF.md
# Serial Audio Frame Receiver (Stereo and TDM)

This block turns a serial audio stream into parallel 32-bit sample words. The stream has a bit clock, a frame clock and up to four data lanes. The bit clock and frame clock are oversampled in the system clock domain. Every rising bit-clock edge shifts one bit into a shift register for each lane. A shared position counter knows where each word ends and, at that point, delivers the word of every active lane together. The delivery carries a slot index.

A 2-bit framing field selects one of two kinds of framing:
- Plain two-channel framing: MSB-justified, LSB-justified or I2S.
- Time-division framing with 4, 8 or 16 slots of 32 bit clocks each.

The framing field also sets how many lanes carry data. A fixed-select input bypasses the format and word-length fields and chooses between 32-bit MSB-justified and 32-bit I2S with one pin.

The receiver counts bit clocks between frame starts and compares the count with the selected framing. A frame of the wrong length raises a frame-error flag. Deliveries are then withheld until a frame of the right length has been received from start to start. Deliveries are also withheld after reset until the first whole clean frame has been seen.

Top module: `aud_rx_deser`

## Requirements
- R1: During and directly after synchronous reset `smp_vld_o` is 0, `smp_slot_o` and `smp_data_o` are 0 and `frame_err_o` is 0.
- R2: Two-channel MSB-justified (`fmt_sel_i`=00, `tdm_sel_i`=00) frames are 64 bit clocks long. Frame clock high marks the left word (slot 0) and low marks the right word (slot 1). Each word starts with its MSB on the first bit clock of its half. With `wlen_sel_i`=10 (24-bit), the low 8 bits of the delivered word are 0. Any other word-length code delivers all 32 bits.
- R3: LSB-justified (`fmt_sel_i`=01) takes the last N bits of each 32-bit half, where N is 16, 20, 24 or 32 for `wlen_sel_i` 00, 01, 10 or 11. The word is sign-extended from bit N-1 to 32 bits.
- R4: I2S (`fmt_sel_i`=10) places the left word while the frame clock is low and the right word while it is high. The MSB comes one bit clock after the frame-clock edge, so the right word is delivered on the first bit of the next frame.
- R5: `tdm_sel_i` 01, 10 and 11 give frames of 128, 256 and 512 bit clocks. Slots are 32 bits wide and MSB first, and `fmt_sel_i`/`wlen_sel_i` are ignored. A rising frame-clock edge starts slot 0, and `smp_slot_o` gives the slot number.
- R6: Active lanes: all four in two-channel mode, lanes 0 and 1 for 128 and 256 bit-clock frames, and only lane 0 for 512 bit-clock frames. An inactive lane never raises its `smp_vld_o` bit, whatever its data input does.
- R7: With `fixed_en_i`=1, `fixed_i2s_i`=0 selects 32-bit MSB-justified and `fixed_i2s_i`=1 selects 32-bit I2S. `fmt_sel_i` and `wlen_sel_i` then have no effect.
- R8: A word is delivered one system clock after the rising bit-clock sample that carries its last bit, as a one-clock pulse. Nothing is delivered until one complete frame of the correct length has been seen from start to start after reset.
- R9: If a frame start arrives after the wrong number of bit clocks, `frame_err_o` rises and deliveries stop. After the next frame of the correct length has completed, `frame_err_o` clears and deliveries resume.
- R10: A frame that runs past the selected length raises `frame_err_o` on the first excess bit, without waiting for the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock; data sampled on its rising edge |
| fclk_i | input | 1 | Frame / channel clock |
| sdata_i | input | 4 | Serial data lanes, lane 0 in bit 0 |
| tdm_sel_i | input | 2 | Framing: 00 two-channel, 01 128, 10 256, 11 512 bit clocks |
| fmt_sel_i | input | 2 | Two-channel format: 00 MSB-justified, 01 LSB-justified, 10 I2S |
| wlen_sel_i | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| fixed_en_i | input | 1 | Use the single-pin format select instead of the fields |
| fixed_i2s_i | input | 1 | Fixed select: 0 MSB-justified 32-bit, 1 I2S 32-bit |
| smp_vld_o | output | 4 | Per-lane delivery strobe, one clock long |
| smp_slot_o | output | 4 | Slot (channel) index of the delivered words |
| smp_data_o | output | 128 | Delivered words, lane n in bits 32n+31..32n |
| frame_err_o | output | 1 | Frame-length error flag |

## Verification
Two events can fall on the same bit-clock edge in I2S mode. The right word of the previous frame is delivered on the first bit of the next frame, which is also the bit on which that frame's length is judged. The bench provokes this by starting every I2S run with a warm-up frame. The first word it expects is the warm-up frame's right word, so delivery has to use the verdict taken on that same edge. In the over-long-frame test, the last in-range capture (bit 63) is followed directly by the first excess bit. The bench expects the word from bit 63 to be delivered and `frame_err_o` to be set before any later frame start.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int unsigned MAX_LANES  = 4;
    localparam int unsigned SLOT_BITS  = 32;
    localparam int unsigned POS_W      = 10;
    localparam int unsigned SLOT_IDX_W = 4;
    localparam int unsigned SLOT_LSB   = $clog2(SLOT_BITS);

    typedef enum logic [1:0] {
        FMT_MSB  = 2'b00,
        FMT_LSB  = 2'b01,
        FMT_I2S  = 2'b10,
        FMT_RSVD = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        TDM_OFF = 2'b00,
        TDM_128 = 2'b01,
        TDM_256 = 2'b10,
        TDM_512 = 2'b11
    } tdm_e;

    typedef enum logic [1:0] {
        WL_16 = 2'b00,
        WL_20 = 2'b01,
        WL_24 = 2'b10,
        WL_32 = 2'b11
    } wlen_e;

    typedef struct packed {
        tdm_e  tdm;
        fmt_e  fmt;
        wlen_e wl;
    } rx_cfg_t;

    typedef struct packed {
        logic                  vld;
        logic [SLOT_IDX_W-1:0] slot;
    } cap_t;

    function automatic logic [POS_W-1:0] last_pos(tdm_e t);
        case (t)
            TDM_OFF: return POS_W'(2 * SLOT_BITS - 1);
            TDM_128: return POS_W'(4 * SLOT_BITS - 1);
            TDM_256: return POS_W'(8 * SLOT_BITS - 1);
            default: return POS_W'(16 * SLOT_BITS - 1);
        endcase
    endfunction

    function automatic logic [SLOT_IDX_W:0] slot_count(tdm_e t);
        case (t)
            TDM_OFF: return (SLOT_IDX_W+1)'(2);
            TDM_128: return (SLOT_IDX_W+1)'(4);
            TDM_256: return (SLOT_IDX_W+1)'(8);
            default: return (SLOT_IDX_W+1)'(16);
        endcase
    endfunction

    function automatic logic [MAX_LANES-1:0] lane_mask(tdm_e t);
        case (t)
            TDM_OFF:          return 4'b1111;
            TDM_128, TDM_256: return 4'b0011;
            default:          return 4'b0001;
        endcase
    endfunction

    function automatic rx_cfg_t resolve_cfg(logic [1:0] tdm_s, logic [1:0] fmt_s,
                                            logic [1:0] wl_s, logic fix_en, logic fix_i2s);
        rx_cfg_t c;
        c.tdm = tdm_e'(tdm_s);
        if (fix_en) begin
            c.fmt = fix_i2s ? FMT_I2S : FMT_MSB;
            c.wl  = WL_32;
        end else begin
            c.fmt = fmt_e'(fmt_s);
            c.wl  = wlen_e'(wl_s);
        end
        return c;
    endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bclk_i,
    input  logic fclk_i,
    input  logic start_on_fall_i,
    output logic bit_stb_o,
    output logic frm_start_o
);

    logic bclk_q;
    logic fclk_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bclk_q <= 1'b0;
            fclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk_i;
            if (bit_stb_o) begin
                fclk_q <= fclk_i;
            end
        end
    end

    assign bit_stb_o   = bclk_i & ~bclk_q;
    assign frm_start_o = bit_stb_o & (start_on_fall_i ? (~fclk_i & fclk_q)
                                                      : (fclk_i & ~fclk_q));

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
    import aud_rx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_stb_i,
    input  logic frm_start_i,
    input  tdm_e tdm_i,
    input  logic i2s_i,
    output cap_t cap_o,
    output logic err_o
);

    logic [POS_W-1:0] pos_q, pos_nxt, last;
    logic seen_q, seen_nxt, lock_q, lock_nxt, err_nxt, word_end;

    assign last = last_pos(tdm_i);

    always_comb begin
        pos_nxt  = pos_q;
        seen_nxt = seen_q;
        lock_nxt = lock_q;
        err_nxt  = err_o;
        if (bit_stb_i) begin
            if (frm_start_i) begin
                pos_nxt  = '0;
                seen_nxt = 1'b1;
                if (seen_q) begin
                    lock_nxt = (pos_q == last);
                    err_nxt  = (pos_q != last);
                end
            end else if (seen_q) begin
                pos_nxt = (pos_q == '1) ? pos_q : pos_q + 1'b1;
                if (pos_q >= last) begin
                    lock_nxt = 1'b0;
                    err_nxt  = 1'b1;
                end
            end
        end
    end

    assign word_end = i2s_i ? (pos_nxt[SLOT_LSB-1:0] == '0)
                            : (pos_nxt[SLOT_LSB-1:0] == '1);

    always_comb begin
        cap_o.vld  = bit_stb_i & seen_nxt & word_end & lock_nxt;
        cap_o.slot = i2s_i ? {{(SLOT_IDX_W-1){1'b0}}, ~pos_nxt[SLOT_LSB]}
                           : pos_nxt[SLOT_LSB +: SLOT_IDX_W];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q  <= '0;
            seen_q <= 1'b0;
            lock_q <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            pos_q  <= pos_nxt;
            seen_q <= seen_nxt;
            lock_q <= lock_nxt;
            err_o  <= err_nxt;
        end
    end

    AST_LOCK_AT_START: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_q) |-> $past(frm_start_i)); // R8

    AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_stb_i && !frm_start_i && seen_q && (pos_q >= last)) |=> err_o); // R10

endmodule

// File: rtl/aud_rx_lane.sv
module aud_rx_lane
    import aud_rx_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 bit_stb_i,
    input  logic                 sd_i,
    input  rx_cfg_t              cfg_i,
    output logic [SLOT_BITS-1:0] word_o
);

    logic [SLOT_BITS-2:0] shreg_q;
    logic [SLOT_BITS-1:0] sh_nxt;

    assign sh_nxt = {shreg_q, sd_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= '0;
        end else if (bit_stb_i) begin
            shreg_q <= sh_nxt[SLOT_BITS-2:0];
        end
    end

    always_comb begin
        word_o = sh_nxt;
        if (cfg_i.tdm == TDM_OFF) begin
            if (cfg_i.fmt == FMT_MSB && cfg_i.wl == WL_24) begin
                word_o = {sh_nxt[SLOT_BITS-1:8], 8'h00};
            end else if (cfg_i.fmt == FMT_LSB) begin
                case (cfg_i.wl)
                    WL_16:   word_o = {{16{sh_nxt[15]}}, sh_nxt[15:0]};
                    WL_20:   word_o = {{12{sh_nxt[19]}}, sh_nxt[19:0]};
                    WL_24:   word_o = {{8{sh_nxt[23]}}, sh_nxt[23:0]};
                    default: word_o = sh_nxt;
                endcase
            end
        end
    end

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter int unsigned LANES = MAX_LANES
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       bclk_i,
    input  logic                       fclk_i,
    input  logic [LANES-1:0]           sdata_i,
    input  logic [1:0]                 tdm_sel_i,
    input  logic [1:0]                 fmt_sel_i,
    input  logic [1:0]                 wlen_sel_i,
    input  logic                       fixed_en_i,
    input  logic                       fixed_i2s_i,
    output logic [LANES-1:0]           smp_vld_o,
    output logic [SLOT_IDX_W-1:0]      smp_slot_o,
    output logic [LANES*SLOT_BITS-1:0] smp_data_o,
    output logic                       frame_err_o
);

    rx_cfg_t                  cfg;
    logic                     i2s_stereo, bit_stb, frm_start;
    cap_t                     cap;
    logic [LANES-1:0]         act_mask;
    logic [LANES*SLOT_BITS-1:0] lane_words;

    assign cfg        = resolve_cfg(tdm_sel_i, fmt_sel_i, wlen_sel_i, fixed_en_i, fixed_i2s_i);
    assign i2s_stereo = (cfg.tdm == TDM_OFF) && (cfg.fmt == FMT_I2S);
    assign act_mask   = lane_mask(cfg.tdm);

    aud_rx_edge u_edge (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .bclk_i          (bclk_i),
        .fclk_i          (fclk_i),
        .start_on_fall_i (i2s_stereo),
        .bit_stb_o       (bit_stb),
        .frm_start_o     (frm_start)
    );

    aud_rx_framer u_framer (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bit_stb_i   (bit_stb),
        .frm_start_i (frm_start),
        .tdm_i       (cfg.tdm),
        .i2s_i       (i2s_stereo),
        .cap_o       (cap),
        .err_o       (frame_err_o)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        aud_rx_lane u_lane (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .bit_stb_i (bit_stb),
            .sd_i      (sdata_i[l]),
            .cfg_i     (cfg),
            .word_o    (lane_words[l*SLOT_BITS +: SLOT_BITS])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            smp_vld_o  <= '0;
            smp_slot_o <= '0;
            smp_data_o <= '0;
        end else begin
            smp_vld_o <= cap.vld ? act_mask : '0;
            if (cap.vld) begin
                smp_slot_o <= cap.slot;
                smp_data_o <= lane_words;
            end
        end
    end

    AST_ERR_MUTES: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_err_o |-> (smp_vld_o == '0)); // R9

    AST_LANE_MASK: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_vld_o & ~act_mask) == '0); // R6

    AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (|smp_vld_o) |-> ({1'b0, smp_slot_o} < slot_count(cfg.tdm))); // R5

    AST_VLD_AFTER_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        (|smp_vld_o) |-> ($past(bclk_i) && !$past(bclk_i, 2))); // R8

    AST_LSB16_SIGN: assert property (@(posedge clk_i) disable iff (rst_i)
        (smp_vld_o[0] && cfg.tdm == TDM_OFF && cfg.fmt == FMT_LSB && cfg.wl == WL_16)
        |-> (smp_data_o[31:16] == {16{smp_data_o[15]}})); // R3

endmodule

// File: tb/aud_rx_deser_tb_top.sv
module aud_rx_deser_tb_top;

    typedef struct packed {
        logic [23:0] tag;
        logic [1:0]  tdm;
        logic [1:0]  fmt;
        logic [1:0]  wl;
        logic        fen;
        logic        fi2s;
    } tvec_t;

    localparam int NVEC = 12;
    localparam tvec_t VECS [NVEC] = '{
        '{"R2 ", 2'd0, 2'd0, 2'd3, 1'b0, 1'b0},
        '{"R2 ", 2'd0, 2'd0, 2'd2, 1'b0, 1'b0},
        '{"R3 ", 2'd0, 2'd1, 2'd0, 1'b0, 1'b0},
        '{"R3 ", 2'd0, 2'd1, 2'd1, 1'b0, 1'b0},
        '{"R3 ", 2'd0, 2'd1, 2'd2, 1'b0, 1'b0},
        '{"R3 ", 2'd0, 2'd1, 2'd3, 1'b0, 1'b0},
        '{"R4 ", 2'd0, 2'd2, 2'd3, 1'b0, 1'b0},
        '{"R5 ", 2'd1, 2'd0, 2'd3, 1'b0, 1'b0},
        '{"R5 ", 2'd2, 2'd1, 2'd0, 1'b0, 1'b0},
        '{"R6 ", 2'd3, 2'd2, 2'd1, 1'b0, 1'b0},
        '{"R7 ", 2'd0, 2'd1, 2'd0, 1'b1, 1'b1},
        '{"R7 ", 2'd0, 2'd2, 2'd0, 1'b1, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bclk = 1'b0, fclk = 1'b0;
    logic [3:0]   sdata = '0;
    logic [1:0]   tdm_sel = '0, fmt_sel = '0, wlen_sel = '0;
    logic         fixed_en = 1'b0, fixed_i2s = 1'b0;
    logic [3:0]   smp_vld;
    logic [3:0]   smp_slot;
    logic [127:0] smp_data;
    logic         frame_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [1:0] eff_fmt, eff_wl, eff_tdm;

    logic [31:0] exp_data [256];
    int          exp_lane [256], exp_slot [256];
    int          exp_n = 0;
    logic [31:0] obs_data [256];
    int          obs_lane [256], obs_slot [256];
    int          obs_n = 0;
    bit          clr_obs = 1'b0;

    always #5 clk = ~clk;

    aud_rx_deser dut_i (
        .clk_i(clk), .rst_i(rst), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
        .tdm_sel_i(tdm_sel), .fmt_sel_i(fmt_sel), .wlen_sel_i(wlen_sel),
        .fixed_en_i(fixed_en), .fixed_i2s_i(fixed_i2s),
        .smp_vld_o(smp_vld), .smp_slot_o(smp_slot), .smp_data_o(smp_data),
        .frame_err_o(frame_err)
    );

    always @(negedge clk) begin
        if (clr_obs) begin
            obs_n = 0;
        end else if (!rst) begin
            for (int l = 0; l < 4; l++) begin
                if (smp_vld[l] && obs_n < 256) begin
                    obs_lane[obs_n] = l;
                    obs_slot[obs_n] = int'(smp_slot);
                    obs_data[obs_n] = smp_data[l*32 +: 32];
                    obs_n++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    function automatic int wl_bits(logic [1:0] w);
        case (w)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [3:0] act_lanes();
        case (eff_tdm)
            2'd0: return 4'b1111;
            2'd3: return 4'b0001;
            default: return 4'b0011;
        endcase
    endfunction

    function automatic logic [31:0] word_of(int tc, int f, int l, int s);
        logic [31:0] a;
        a = 32'(tc * 4096 + f * 256 + l * 32 + s + 1);
        return a * 32'h9E3779B1;
    endfunction

    function automatic logic [31:0] exp_val(logic [31:0] w);
        if (eff_fmt == 2'd1) begin
            case (eff_wl)
                2'd0: return {{16{w[15]}}, w[15:0]};
                2'd1: return {{12{w[19]}}, w[19:0]};
                2'd2: return {{8{w[23]}}, w[23:0]};
                default: return w;
            endcase
        end
        if (eff_fmt == 2'd0 && eff_wl == 2'd2) return {w[31:8], 8'h00};
        return w;
    endfunction

    function automatic logic bit_at(int tc, int f, int l, int b);
        int s, k, ff;
        logic [31:0] w;
        if (eff_fmt == 2'd2) begin
            if (b == 0) begin ff = f - 1; s = 1; k = 31; end
            else begin ff = f; s = (b - 1) / 32; k = (b - 1) % 32; end
            if (ff < 0) return 1'b0;
            w = word_of(tc, ff, l, s);
            return w[31-k];
        end
        s = b / 32;
        k = b % 32;
        w = word_of(tc, f, l, s);
        if (eff_fmt == 2'd1) return (k >= 32 - wl_bits(eff_wl)) ? w[31-k] : 1'b1;
        if (eff_wl == 2'd2) return (k < 24) ? w[31-k] : 1'b1;
        return w[31-k];
    endfunction

    task automatic push_all(int tc, int f, int s);
        logic [3:0] m;
        m = act_lanes();
        for (int l = 0; l < 4; l++) begin
            if (m[l] && exp_n < 256) begin
                exp_lane[exp_n] = l;
                exp_slot[exp_n] = s;
                exp_data[exp_n] = exp_val(word_of(tc, f, l, s));
                exp_n++;
            end
        end
    endtask

    task automatic send_bit(logic fc, logic [3:0] d);
        @(negedge clk);
        bclk = 1'b0; fclk = fc; sdata = d;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_frame(int tc, int f, int nbits, bit exp_en);
        for (int b = 0; b < nbits; b++) begin
            logic fc;
            logic [3:0] d;
            fc = (eff_fmt == 2'd2) ? (b >= 32) : (b < 32);
            for (int l = 0; l < 4; l++) d[l] = bit_at(tc, f, l, b);
            send_bit(fc, d);
            if (exp_en) begin
                if (eff_fmt == 2'd2) begin
                    if (b == 0) push_all(tc, f - 1, 1);
                    else if (b == 32) push_all(tc, f, 0);
                end else if (b % 32 == 31) begin
                    push_all(tc, f, b / 32);
                end
            end
        end
    endtask

    task automatic setup(tvec_t v);
        tdm_sel = v.tdm; fmt_sel = v.fmt; wlen_sel = v.wl;
        fixed_en = v.fen; fixed_i2s = v.fi2s;
        eff_tdm = v.tdm;
        if (v.tdm != 2'd0) begin eff_fmt = 2'd0; eff_wl = 2'd3; end
        else if (v.fen) begin eff_fmt = v.fi2s ? 2'd2 : 2'd0; eff_wl = 2'd3; end
        else begin eff_fmt = v.fmt; eff_wl = v.wl; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bclk = 1'b0; fclk = 1'b0; sdata = '0; clr_obs = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; clr_obs = 1'b0;
        exp_n = 0;
        send_bit((eff_fmt == 2'd2), 4'h0);
    endtask

    task automatic compare(string tag);
        repeat (6) @(negedge clk);
        chk(obs_n == exp_n, "R8 word count", 32'(obs_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < obs_n; i++) begin
            chk(obs_lane[i] == exp_lane[i] && obs_slot[i] == exp_slot[i] && obs_data[i] === exp_data[i],
                $sformatf("%s word %0d lane %0d/%0d slot %0d/%0d", tag, i, obs_lane[i], exp_lane[i],
                          obs_slot[i], exp_slot[i]), obs_data[i], exp_data[i]);
        end
    endtask

    initial begin
        int frame_len;
        eff_fmt = 2'd0; eff_wl = 2'd3; eff_tdm = 2'd0;
        // R1: outputs quiet during and after reset
        repeat (3) @(negedge clk);
        chk(smp_vld == 4'h0, "R1 vld in reset", 32'(smp_vld), 32'h0);
        chk(frame_err == 1'b0, "R1 err in reset", 32'(frame_err), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(smp_data == '0 && smp_slot == '0, "R1 data after reset", smp_data[31:0], 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            setup(VECS[v]);
            do_reset();
            frame_len = (VECS[v].tdm == 2'd0) ? 64 : (64 << VECS[v].tdm);
            for (int f = 0; f < 3; f++) send_frame(v, f, frame_len, f >= 1);
            compare(string'(VECS[v].tag));
        end

        // R9: short frame, then recovery after a clean frame
        setup('{"R9 ", 2'd0, 2'd0, 2'd3, 1'b0, 1'b0});
        do_reset();
        send_frame(20, 0, 64, 1'b0);
        send_frame(20, 1, 64, 1'b1);
        send_frame(20, 2, 40, 1'b1);
        chk(frame_err == 1'b0, "R9 not yet judged", 32'(frame_err), 32'h0);
        send_frame(20, 3, 64, 1'b0);
        chk(frame_err == 1'b1, "R9 short frame flagged", 32'(frame_err), 32'h1);
        send_frame(20, 4, 64, 1'b1);
        chk(frame_err == 1'b0, "R9 cleared after clean frame", 32'(frame_err), 32'h0);
        compare("R9");

        // R10: over-long frame flagged on its first excess bit
        setup('{"R10", 2'd0, 2'd0, 2'd3, 1'b0, 1'b0});
        do_reset();
        send_frame(21, 0, 64, 1'b0);
        send_frame(21, 1, 64, 1'b1);
        send_frame(21, 2, 65, 1'b1);
        chk(frame_err == 1'b1, "R10 overrun flagged early", 32'(frame_err), 32'h1);
        send_frame(21, 3, 64, 1'b0);
        chk(frame_err == 1'b1, "R10 error held", 32'(frame_err), 32'h1);
        send_frame(21, 4, 64, 1'b1);
        chk(frame_err == 1'b0, "R10 recovered", 32'(frame_err), 32'h0);
        compare("R10");

        finish_run();
    end

endmodule